// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with Set-Associative TLB

This block turns a 14-bit virtual address into a 12-bit physical address for a small paged memory with 64-byte pages. A 16-entry translation cache sits in front of a 256-entry single-level page table. The cache is organised as 4 sets of 4 ways. A request that hits the cache is answered one cycle after it is accepted. A request that misses reads the page table for one more cycle. If the page-table entry is valid, its translation is written back into the cache. If the entry is invalid, the block reports a page fault.

The block has two states, `S_IDLE` and `S_WALK`. In `S_IDLE` a valid request is looked up at once. A hit stays in `S_IDLE` (transition "idle-hit"). A miss moves to `S_WALK` (transition "idle-miss"). `S_WALK` always returns to `S_IDLE` on the next edge (transition "walk-done"). On that edge it writes the response and, when there is no fault, the refill. A separate load port lets the surrounding logic write any cache way or page-table entry, so the translation state can be set up before use.

Top module: `xlat_unit`

## Requirements
- R1: After reset the done, hit and fault outputs and the physical address are all zero. Every cache way and every page-table entry is invalid, so a first request on any address reports a fault.
- R2: The virtual page number is VA[13:6]. The cache set is VA[7:6] and the cache tag is VA[13:8]. VA[5:0] is copied to PA[5:0], and the page frame number fills PA[11:6].
- R3: A request accepted in `S_IDLE` whose set holds a valid way with a matching tag gives done=1, hit=1, fault=0 and the translated address in the cycle after acceptance. For example, VA 0x03D4 with set 3, tag 0x03 mapped to frame 0x0D gives 0x354.
- R4: A request that misses the cache gives done=1 and hit=0 two cycles after acceptance. When the page-table entry is valid, fault=0 and the address comes from that entry. For example, VA 0x0020 with entry 0 mapped to frame 0x28 gives 0xA20.
- R5: A miss whose page-table entry is invalid gives fault=1, hit=0 and PA=0, and leaves the cache unchanged. Repeating the request after the entry becomes valid still misses the cache.
- R6: A miss that does not fault writes its translation into the indexed set. The next request to the same page hits.
- R7: A refill goes into the lowest-numbered invalid way of its set.
- R8: When all four ways of the set are valid, the refill evicts the way named by that set's own rotating pointer. The pointer starts at way 0 and advances by one only on such an eviction.
- R9: A request presented while the block is in `S_WALK` is ignored and produces no response.
- R10: With ld_en=1, ld_tlb=1 writes way ld_way of set ld_vpn[1:0], giving it tag ld_vpn[7:2], frame ld_ppn and valid bit ld_valid. With ld_tlb=0 the same port writes page-table entry ld_vpn. A way loaded invalid no longer hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken in `S_IDLE` only |
| req_va | input | 14 | Virtual address to translate |
| ld_en | input | 1 | Load-port write strobe |
| ld_tlb | input | 1 | 1 selects a cache way, 0 selects a page-table entry |
| ld_way | input | 2 | Cache way written by the load port |
| ld_vpn | input | 8 | Page number giving the set and tag, or the table index |
| ld_ppn | input | 6 | Frame number to store |
| ld_valid | input | 1 | Valid bit to store |
| rsp_done | output | 1 | One-cycle pulse marking a response |
| rsp_hit | output | 1 | Response came from the cache |
| rsp_fault | output | 1 | Page-table entry was invalid |
| rsp_pa | output | 12 | Physical address, zero on a fault |

## Verification
Two things meet in the `S_WALK` cycle: the cache refill write, and the arrival of a new request that must be dropped. The bench holds a missing request high across both accept and walk cycles. A correct design gives exactly one response, at the two-cycle latency. A stray second response is caught by the scoreboard as an unexpected item. After the walk, a follow-up request to the same page must come back as a hit, which shows the refill landed in the cycle the request was dropped. The rotating victim pointers are judged the same way. Sequences of misses fill a set, evict from it, and are then probed by hits and misses, so every eviction is observed at the ports.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_WALK = 1'b1
    } xlat_state_e;
endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int PPN_W = 6,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic [SET_W-1:0] vc_set,
    output logic [WAY_W-1:0] vc_way,
    output logic             vc_full,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_vld,
    input  logic             wr_adv
);
    logic [WAYS-1:0]  vld_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [PPN_W-1:0] ppn_q [SETS][WAYS];
    logic [WAY_W-1:0] rr_q  [SETS];
    logic [WAYS-1:0]  match;
    logic             found;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                rr_q[s]  <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_set][wr_way] <= wr_vld;
            if (wr_adv) rr_q[wr_set] <= rr_q[wr_set] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way] <= wr_tag;
            ppn_q[wr_set][wr_way] <= wr_ppn;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    assign lk_hit = |match;

    always_comb begin
        lk_ppn = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) lk_ppn = ppn_q[lk_set][w];
        end
    end

    always_comb begin
        vc_full = &vld_q[vc_set];
        vc_way  = rr_q[vc_set];
        found   = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !vld_q[vc_set][w]) begin
                vc_way = WAY_W'(w);
                found  = 1'b1;
            end
        end
    end

    AST_ADV_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_adv |-> &vld_q[wr_set]); // R8
    AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_adv |=> rr_q[$past(wr_set)] == WAY_W'($past(rr_q[wr_set]) + 1'b1)); // R8
endmodule

// File: rtl/xlat_ptab.sv
module xlat_ptab #(
    parameter int DEPTH = 256,
    parameter int PPN_W = 6,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PPN_W-1:0] rd_ppn,
    output logic             rd_vld,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_vld
);
    logic [DEPTH-1:0] vld_q;
    logic [PPN_W-1:0] ppn_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n)     vld_q <= '0;
        else if (wr_en) vld_q[wr_idx] <= wr_vld;
    end

    always_ff @(posedge clk) begin
        if (wr_en) ppn_q[wr_idx] <= wr_ppn;
    end

    assign rd_ppn = ppn_q[rd_idx];
    assign rd_vld = vld_q[rd_idx];
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int VA_W  = 14,
    parameter int PA_W  = 12,
    parameter int OFF_W = 6,
    parameter int SETS  = 4,
    parameter int WAYS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [VA_W-1:0]         req_va,
    input  logic                    ld_en,
    input  logic                    ld_tlb,
    input  logic [$clog2(WAYS)-1:0] ld_way,
    input  logic [VA_W-OFF_W-1:0]   ld_vpn,
    input  logic [PA_W-OFF_W-1:0]   ld_ppn,
    input  logic                    ld_valid,
    output logic                    rsp_done,
    output logic                    rsp_hit,
    output logic                    rsp_fault,
    output logic [PA_W-1:0]         rsp_pa
);
    localparam int VPN_W    = VA_W - OFF_W;
    localparam int PPN_W    = PA_W - OFF_W;
    localparam int SET_W    = $clog2(SETS);
    localparam int WAY_W    = $clog2(WAYS);
    localparam int TAG_W    = VPN_W - SET_W;
    localparam int PT_DEPTH = 1 << VPN_W;

    xlat_state_e      state_q, state_d;
    logic [VA_W-1:0]  va_q;
    logic [VPN_W-1:0] req_vpn, q_vpn;
    logic             tlb_hit, pt_vld, vc_full, refill;
    logic [PPN_W-1:0] tlb_ppn, pt_ppn;
    logic [WAY_W-1:0] vc_way;
    logic             tw_en, tw_vld;
    logic [SET_W-1:0] tw_set;
    logic [WAY_W-1:0] tw_way;
    logic [TAG_W-1:0] tw_tag;
    logic [PPN_W-1:0] tw_ppn;

    assign req_vpn = req_va[VA_W-1:OFF_W];
    assign q_vpn   = va_q[VA_W-1:OFF_W];
    assign refill  = (state_q == S_WALK) && pt_vld;

    // Refill takes the cache write port ahead of the load port.
    assign tw_en  = refill || (ld_en && ld_tlb);
    assign tw_set = refill ? q_vpn[SET_W-1:0]     : ld_vpn[SET_W-1:0];
    assign tw_tag = refill ? q_vpn[VPN_W-1:SET_W] : ld_vpn[VPN_W-1:SET_W];
    assign tw_way = refill ? vc_way               : ld_way;
    assign tw_ppn = refill ? pt_ppn               : ld_ppn;
    assign tw_vld = refill ? 1'b1                 : ld_valid;

    xlat_tlb #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_tlb (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_set  (req_vpn[SET_W-1:0]),
        .lk_tag  (req_vpn[VPN_W-1:SET_W]),
        .lk_hit  (tlb_hit),
        .lk_ppn  (tlb_ppn),
        .vc_set  (q_vpn[SET_W-1:0]),
        .vc_way  (vc_way),
        .vc_full (vc_full),
        .wr_en   (tw_en),
        .wr_set  (tw_set),
        .wr_way  (tw_way),
        .wr_tag  (tw_tag),
        .wr_ppn  (tw_ppn),
        .wr_vld  (tw_vld),
        .wr_adv  (refill && vc_full)
    );

    xlat_ptab #(.DEPTH(PT_DEPTH), .PPN_W(PPN_W)) u_ptab (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (q_vpn),
        .rd_ppn (pt_ppn),
        .rd_vld (pt_vld),
        .wr_en  (ld_en && !ld_tlb),
        .wr_idx (ld_vpn),
        .wr_ppn (ld_ppn),
        .wr_vld (ld_valid)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid && !tlb_hit) state_d = S_WALK;
            S_WALK: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            va_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_valid) va_q <= req_va;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_pa    <= '0;
        end else begin
            rsp_done <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid && tlb_hit) begin
                        rsp_done  <= 1'b1;
                        rsp_hit   <= 1'b1;
                        rsp_fault <= 1'b0;
                        rsp_pa    <= {tlb_ppn, req_va[OFF_W-1:0]};
                    end
                end
                S_WALK: begin
                    rsp_done  <= 1'b1;
                    rsp_hit   <= 1'b0;
                    rsp_fault <= !pt_vld;
                    rsp_pa    <= pt_vld ? {pt_ppn, va_q[OFF_W-1:0]} : '0;
                end
                default: ;
            endcase
        end
    end

    AST_WALK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_WALK |=> state_q == S_IDLE); // R4
    AST_WALK_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_WALK |=> rsp_done && !rsp_hit); // R4
    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_IDLE && req_valid && tlb_hit |=> rsp_done && rsp_hit && !rsp_fault); // R3
    AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done && rsp_fault |-> rsp_pa == '0 && !rsp_hit); // R5
    AST_WALK_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_WALK |=> $stable(va_q)); // R9
endmodule

// File: tb/sim_xlat_unit.sv
module sim_xlat_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [13:0] req_va = '0;
    logic        ld_en = 1'b0;
    logic        ld_tlb = 1'b0;
    logic [1:0]  ld_way = '0;
    logic [7:0]  ld_vpn = '0;
    logic [5:0]  ld_ppn = '0;
    logic        ld_valid = 1'b0;
    logic        rsp_done, rsp_hit, rsp_fault;
    logic [11:0] rsp_pa;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        bit          hit;
        bit          flt;
        logic [11:0] pa;
        int          cyc;
        string       rq;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    xlat_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .ld_en(ld_en), .ld_tlb(ld_tlb), .ld_way(ld_way), .ld_vpn(ld_vpn),
        .ld_ppn(ld_ppn), .ld_valid(ld_valid),
        .rsp_done(rsp_done), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
    );

    // Monitor: pops one expected item per response.
    always @(negedge clk) begin
        if (rst_n && rsp_done) begin
            exp_t e;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected response: actual done=1 expected done=0");
            end else begin
                e = exp_q.pop_front();
                if (rsp_hit !== e.hit || rsp_fault !== e.flt || rsp_pa !== e.pa || cyc != e.cyc) begin
                    errors++;
                    $display("FAIL %s: actual hit=%0b fault=%0b pa=%h cyc=%0d expected hit=%0b fault=%0b pa=%h cyc=%0d",
                             e.rq, rsp_hit, rsp_fault, rsp_pa, cyc, e.hit, e.flt, e.pa, e.cyc);
                end
            end
        end
    end

    task automatic load(input bit tlb, input logic [1:0] way, input logic [7:0] vpn,
                        input logic [5:0] ppn, input bit vld);
        @(posedge clk); #1;
        ld_en = 1'b1; ld_tlb = tlb; ld_way = way; ld_vpn = vpn; ld_ppn = ppn; ld_valid = vld;
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    // Driver: pushes the expected result, then issues the request.
    task automatic xreq(input logic [7:0] vpn, input logic [5:0] off, input bit hit,
                        input bit flt, input logic [5:0] ppn, input int hold, input string rq);
        exp_t e;
        @(posedge clk); #1;
        e.hit = hit;
        e.flt = flt;
        e.pa  = flt ? 12'h000 : {ppn, off};
        e.cyc = cyc + (hit ? 1 : 2);
        e.rq  = rq;
        exp_q.push_back(e);
        req_va = {vpn, off};
        req_valid = 1'b1;
        for (int i = 0; i < hold; i++) @(posedge clk);
        #1 req_valid = 1'b0;
        while (exp_q.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual run still going expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_done !== 1'b0 || rsp_hit !== 1'b0 || rsp_fault !== 1'b0 || rsp_pa !== 12'h000) begin
            errors++;
            $display("FAIL R1 reset outputs: actual %b%b%b %h expected 000 000",
                     rsp_done, rsp_hit, rsp_fault, rsp_pa);
        end
        // R1 / R5: nothing loaded, so the walk faults
        xreq(8'h0F, 6'h14, 0, 1, 6'h00, 1, "R1 first request faults");

        // R10 load port, R3 / R2 hit vector 0x03D4 -> 0x354
        load(1, 2'd1, 8'h0F, 6'h0D, 1);
        load(0, 2'd0, 8'h00, 6'h28, 1);
        xreq(8'h0F, 6'h14, 1, 0, 6'h0D, 1, "R3 R2 hit 0x03D4");
        // R4 miss vector 0x0020 -> 0xA20, then R6 refilled hit
        xreq(8'h00, 6'h20, 0, 0, 6'h28, 1, "R4 walk 0x0020");
        xreq(8'h00, 6'h20, 1, 0, 6'h28, 1, "R6 hit after refill");

        // R5: fault leaves cache unchanged
        xreq(8'h05, 6'h07, 0, 1, 6'h00, 1, "R5 fault");
        load(0, 2'd0, 8'h05, 6'h16, 1);
        xreq(8'h05, 6'h07, 0, 0, 6'h16, 1, "R5 no refill on fault");
        xreq(8'h05, 6'h07, 1, 0, 6'h16, 1, "R6 hit after refill");

        // R8: rotating victim in set 2
        load(0, 2'd0, 8'h02, 6'h12, 1);
        load(0, 2'd0, 8'h06, 6'h16, 1);
        load(0, 2'd0, 8'h0A, 6'h1A, 1);
        load(0, 2'd0, 8'h0E, 6'h1E, 1);
        load(0, 2'd0, 8'h12, 6'h22, 1);
        xreq(8'h02, 6'h03, 0, 0, 6'h12, 1, "R7 fill way0");
        xreq(8'h06, 6'h03, 0, 0, 6'h16, 1, "R7 fill way1");
        xreq(8'h0A, 6'h03, 0, 0, 6'h1A, 1, "R7 fill way2");
        xreq(8'h0E, 6'h03, 0, 0, 6'h1E, 1, "R7 fill way3");
        xreq(8'h12, 6'h03, 0, 0, 6'h22, 1, "R8 evict way0");
        xreq(8'h06, 6'h03, 1, 0, 6'h16, 1, "R8 way1 kept");
        xreq(8'h0A, 6'h03, 1, 0, 6'h1A, 1, "R8 way2 kept");
        xreq(8'h0E, 6'h03, 1, 0, 6'h1E, 1, "R8 way3 kept");
        xreq(8'h12, 6'h03, 1, 0, 6'h22, 1, "R8 new entry hits");
        xreq(8'h02, 6'h03, 0, 0, 6'h12, 1, "R8 evicted entry misses");
        xreq(8'h06, 6'h03, 0, 0, 6'h16, 1, "R8 second eviction took way1");
        xreq(8'h0E, 6'h03, 1, 0, 6'h1E, 1, "R8 way3 kept");
        xreq(8'h0A, 6'h03, 0, 0, 6'h1A, 1, "R8 third eviction took way2");
        xreq(8'h12, 6'h03, 1, 0, 6'h22, 1, "R8 way0 kept");
        xreq(8'h02, 6'h03, 1, 0, 6'h12, 1, "R8 way1 kept");
        xreq(8'h06, 6'h03, 1, 0, 6'h16, 1, "R8 way2 kept");
        xreq(8'h0E, 6'h03, 0, 0, 6'h1E, 1, "R8 fourth eviction took way3");

        // R7: first invalid way in set 0, R8 pointer of set 0 independent
        load(1, 2'd2, 8'h04, 6'h30, 1);
        load(0, 2'd0, 8'h08, 6'h31, 1);
        load(0, 2'd0, 8'h0C, 6'h32, 1);
        load(0, 2'd0, 8'h10, 6'h33, 1);
        xreq(8'h08, 6'h11, 0, 0, 6'h31, 1, "R7 fill gap way1");
        xreq(8'h0C, 6'h11, 0, 0, 6'h32, 1, "R7 fill gap way3");
        xreq(8'h00, 6'h11, 1, 0, 6'h28, 1, "R7 way0 kept");
        xreq(8'h04, 6'h11, 1, 0, 6'h30, 1, "R7 loaded way2 kept");
        xreq(8'h08, 6'h11, 1, 0, 6'h31, 1, "R7 way1 hit");
        xreq(8'h0C, 6'h11, 1, 0, 6'h32, 1, "R7 way3 hit");
        xreq(8'h10, 6'h11, 0, 0, 6'h33, 1, "R8 set0 evicts way0");
        xreq(8'h04, 6'h11, 1, 0, 6'h30, 1, "R8 set0 way2 kept");
        xreq(8'h08, 6'h11, 1, 0, 6'h31, 1, "R8 set0 own pointer");
        xreq(8'h0C, 6'h11, 1, 0, 6'h32, 1, "R8 set0 way3 kept");
        xreq(8'h00, 6'h11, 0, 0, 6'h28, 1, "R8 set0 way0 evicted");

        // R9: request held through the walk cycle gives one response
        load(0, 2'd0, 8'h20, 6'h3A, 1);
        xreq(8'h20, 6'h2A, 0, 0, 6'h3A, 2, "R9 held miss");
        xreq(8'h20, 6'h2A, 1, 0, 6'h3A, 1, "R9 R6 refill during ignored request");

        // R10: loading a way invalid removes the hit
        load(1, 2'd1, 8'h0F, 6'h0D, 0);
        xreq(8'h0F, 6'h14, 0, 1, 6'h00, 1, "R10 invalidated way");

        repeat (5) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule